// File: doc/BRIEF.md
# Banked GPIO Controller with Per-Pin Interrupt Detection

This block controls 107 general-purpose pins that are grouped into five banks of unequal width. Software reaches each bank through a small memory-mapped register bus. For every pin it can set the driven level and the drive enable. It can read the synchronized pad level. It can also set up interrupt detection on that pin: edge or level, active high/rising or active low/falling.

The block drives the pad output and output-enable vectors and samples the pad inputs through a synchronizer. Each pin keeps a pending flag that software clears by writing one to it. All pins that are both pending and enabled combine into a single interrupt line.

Top module: `banked_gpio_ctrl`

## Requirements
- R1: The banks hold pins 0–15, 16–42, 43–67, 68–94 and 95–106. In bank b, pin p sits at bit p minus the bank's first pin. The bus address is {bank[2:0], reg[2:0]}, and the register indices are: 0 output level, 1 drive enable, 2 input level, 3 trigger mode, 4 polarity, 5 interrupt mask, 6 acknowledge, 7 pending.
- R2: `pad_out` and `pad_oe` show the output-level and drive-enable register bits one cycle after the write. A drive-enable bit of 1 means the pin is driven.
- R3: The input-level register returns every pin's pad level after a two-flop synchronizer, whatever the pin's direction.
- R4: With trigger mode 1, a pin becomes pending on a rising synchronized edge if its polarity is 1, and on a falling edge if its polarity is 0.
- R5: With trigger mode 0, a pin becomes pending while its synchronized level equals its polarity bit. After a clear, it becomes pending again one cycle later if that level is still present.
- R6: A pin becomes pending only while its mask bit is 1. An existing pending bit is kept when its mask bit goes to 0.
- R7: Writing 1 to an acknowledge bit clears that pending bit on the next cycle. Writing 0 leaves it unchanged. A clear takes priority over a detection in the same cycle.
- R8: `irq` is 1 exactly when some pin is both pending and masked in.
- R9: Bits above a bank's width read 0 and ignore writes. Bank indices 5 to 7 read 0 and ignore writes. The acknowledge register reads 0.
- R10: `bus_rdata` carries the read value in the cycle after a read request. It is 0 in the cycle after any cycle without a read.
- R11: After reset, every register, `pad_out`, `pad_oe`, `irq` and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | {bank index, register index} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| pad_in | input | 107 | Pad input levels (asynchronous) |
| pad_out | output | 107 | Pad output levels |
| pad_oe | output | 107 | Pad drive enables |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong internal state shows up at the ports quickly. A corrupted output-level or drive-enable bit appears on `pad_out` or `pad_oe` in the very next cycle. A wrongly set or missed pending bit changes `irq` in the same cycle, as long as that pin is masked in. Faults in the synchronizer or the edge history change the cycle in which `irq` rises. They also change what a read of the input-level or pending register returns one cycle after the request. Because the reference model is compared on every clock, a fault is caught within one cycle of the point where it could first reach a port.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int NUM_BANKS  = 5;
    localparam int NUM_PINS   = 107;
    localparam int DATA_W     = 32;
    localparam int BANK_IDX_W = 3;
    localparam int REG_IDX_W  = 3;
    localparam int ADDR_W     = BANK_IDX_W + REG_IDX_W;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_LEVEL = 3'd0,
        REG_DRIVE = 3'd1,
        REG_SENSE = 3'd2,
        REG_TRIG  = 3'd3,
        REG_POL   = 3'd4,
        REG_MASK  = 3'd5,
        REG_ACK   = 3'd6,
        REG_PEND  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_PINS-1:0] level;
        logic [NUM_PINS-1:0] drive;
        logic [NUM_PINS-1:0] trig;
        logic [NUM_PINS-1:0] pol;
        logic [NUM_PINS-1:0] mask;
        logic [NUM_PINS-1:0] pend;
        logic [DATA_W-1:0]   rdata;
    } ctrl_state_t;

    function automatic int bank_width(input int b);
        case (b)
            0:       return 16;
            1:       return 27;
            2:       return 25;
            3:       return 27;
            4:       return 12;
            default: return 0;
        endcase
    endfunction

    function automatic int bank_base(input int b);
        int s;
        s = 0;
        for (int i = 0; i < b; i++) s += bank_width(i);
        return s;
    endfunction

    function automatic int max_bank_width();
        int m;
        m = 0;
        for (int i = 0; i < NUM_BANKS; i++)
            if (bank_width(i) > m) m = bank_width(i);
        return m;
    endfunction

endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/pin_event.sv
module pin_event #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] edge_mode,
    input  logic [WIDTH-1:0] active_high,
    output logic [WIDTH-1:0] hit
);

    logic [WIDTH-1:0] prev_d;
    logic [WIDTH-1:0] prev_q;

    assign prev_d = level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign hit[i] = edge_mode[i]
            ? (active_high[i] ? (level[i] & ~prev_q[i]) : (~level[i] & prev_q[i]))
            : (level[i] == active_high[i]);
    end

endmodule

// File: rtl/bank_map.sv
module bank_map
    import pinbank_pkg::*;
(
    input  logic [BANK_IDX_W-1:0] bank_sel,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [NUM_PINS-1:0]   src_vec,
    output logic [NUM_PINS-1:0]   wmask,
    output logic [NUM_PINS-1:0]   wspread,
    output logic [DATA_W-1:0]     rword
);

    localparam int MAX_W = max_bank_width();

    logic [DATA_W-1:0] word [NUM_BANKS];
    logic              unused_hi_bits;

    assign unused_hi_bits = ^wdata[DATA_W-1:MAX_W];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int W    = bank_width(b);
        localparam int BASE = bank_base(b);
        assign wmask[BASE +: W]   = {W{bank_sel == BANK_IDX_W'(b)}};
        assign wspread[BASE +: W] = wdata[W-1:0];
        assign word[b]            = {{(DATA_W-W){1'b0}}, src_vec[BASE +: W]};
    end

    always_comb begin
        rword = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (bank_sel == BANK_IDX_W'(b)) rword = word[b];
    end

endmodule

// File: rtl/banked_gpio_ctrl.sv
module banked_gpio_ctrl
    import pinbank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);

    localparam int PIN_SUM = bank_base(NUM_BANKS);

    initial begin
        if (PIN_SUM != NUM_PINS) $error("bank widths do not cover all pins");
    end

    ctrl_state_t cur_q, nxt_d;

    logic [BANK_IDX_W-1:0] bank_sel;
    reg_sel_e              reg_sel;
    logic                  wr_req, rd_req;
    logic [NUM_PINS-1:0]   sensed, hit, src_vec, wmask, wspread, ack_bits;
    logic [NUM_PINS-1:0]   pend_vec, mask_vec;
    logic [DATA_W-1:0]     rword;

    assign bank_sel = bus_addr[ADDR_W-1 -: BANK_IDX_W];
    assign reg_sel  = reg_sel_e'(bus_addr[REG_IDX_W-1:0]);
    assign wr_req   = bus_valid & bus_write;
    assign rd_req   = bus_valid & ~bus_write;

    pad_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (sensed)
    );

    pin_event #(.WIDTH(NUM_PINS)) u_event (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (sensed),
        .edge_mode  (cur_q.trig),
        .active_high(cur_q.pol),
        .hit        (hit)
    );

    bank_map u_map (
        .bank_sel(bank_sel),
        .wdata   (bus_wdata),
        .src_vec (src_vec),
        .wmask   (wmask),
        .wspread (wspread),
        .rword   (rword)
    );

    function automatic logic [NUM_PINS-1:0] merge_bits(
        input logic [NUM_PINS-1:0] old_v,
        input logic [NUM_PINS-1:0] m,
        input logic [NUM_PINS-1:0] v
    );
        return (old_v & ~m) | (v & m);
    endfunction

    always_comb begin
        case (reg_sel)
            REG_LEVEL: src_vec = cur_q.level;
            REG_DRIVE: src_vec = cur_q.drive;
            REG_SENSE: src_vec = sensed;
            REG_TRIG:  src_vec = cur_q.trig;
            REG_POL:   src_vec = cur_q.pol;
            REG_MASK:  src_vec = cur_q.mask;
            REG_PEND:  src_vec = cur_q.pend;
            default:   src_vec = '0;
        endcase
    end

    always_comb begin
        nxt_d    = cur_q;
        ack_bits = '0;
        if (wr_req) begin
            case (reg_sel)
                REG_LEVEL: nxt_d.level = merge_bits(cur_q.level, wmask, wspread);
                REG_DRIVE: nxt_d.drive = merge_bits(cur_q.drive, wmask, wspread);
                REG_TRIG:  nxt_d.trig  = merge_bits(cur_q.trig,  wmask, wspread);
                REG_POL:   nxt_d.pol   = merge_bits(cur_q.pol,   wmask, wspread);
                REG_MASK:  nxt_d.mask  = merge_bits(cur_q.mask,  wmask, wspread);
                REG_ACK:   ack_bits    = wspread & wmask;
                default:   ;
            endcase
        end
        nxt_d.pend  = (cur_q.pend | (hit & cur_q.mask)) & ~ack_bits;
        nxt_d.rdata = rd_req ? rword : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign pend_vec  = cur_q.pend;
    assign mask_vec  = cur_q.mask;
    assign pad_out   = cur_q.level;
    assign pad_oe    = cur_q.drive;
    assign bus_rdata = cur_q.rdata;
    assign irq       = |(pend_vec & mask_vec);

endmodule

// File: rtl/gpio_ctrl_checks.sv
module gpio_ctrl_checks
    import pinbank_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                bus_valid,
    input logic                bus_write,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pend_vec,
    input logic [NUM_PINS-1:0] mask_vec,
    input logic [NUM_PINS-1:0] ack_bits
);

    logic                  is_wr, is_rd;
    logic [REG_IDX_W-1:0]  ridx;
    logic [BANK_IDX_W-1:0] bidx;

    assign is_wr = bus_valid & bus_write;
    assign is_rd = bus_valid & ~bus_write;
    assign ridx  = bus_addr[REG_IDX_W-1:0];
    assign bidx  = bus_addr[ADDR_W-1 -: BANK_IDX_W];

    p_drive_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_wr && ridx == 3'd1) |=> $stable(pad_oe));

    p_level_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_wr && ridx == 3'd0) |=> $stable(pad_out));

    p_mask_gates_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_vec & ~$past(pend_vec) & ~$past(mask_vec)) == '0));

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && ridx == 3'd6) |=> ((pend_vec & $past(ack_bits)) == '0));

    p_void_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && bidx >= 3'd5) |=> (bus_rdata == '0));

    p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> (bus_rdata == '0));

endmodule

bind banked_gpio_ctrl gpio_ctrl_checks u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_write(bus_write),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pend_vec (pend_vec),
    .mask_vec (mask_vec),
    .ack_bits (ack_bits)
);

// File: tb/tb_banked_gpio_ctrl.sv
module tb_banked_gpio_ctrl;

    localparam int NP = 107;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic          irq;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    cmp_on = 0;
    bit    done = 0;
    string tag = "R11";

    always #5 clk = ~clk;

    banked_gpio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // Reference model state
    bit [NP-1:0] m_lvl, m_drv, m_trig, m_pol, m_msk, m_pend, m_s1, m_s2, m_prev;
    bit [31:0]   m_rd;

    function automatic int bw(int b);
        int w[5] = '{16, 27, 25, 27, 12};
        return (b < 5) ? w[b] : 0;
    endfunction

    function automatic int bb(int b);
        int f[5] = '{0, 16, 43, 68, 95};
        return (b < 5) ? f[b] : 0;
    endfunction

    function automatic bit [31:0] mread(int bk, int rg);
        bit [31:0] r;
        bit [NP-1:0] v;
        r = '0;
        if (bk > 4) return r;
        case (rg)
            0: v = m_lvl;  1: v = m_drv;  2: v = m_s2;   3: v = m_trig;
            4: v = m_pol;  5: v = m_msk;  6: v = '0;     default: v = m_pend;
        endcase
        for (int k = 0; k < bw(bk); k++) r[k] = v[bb(bk) + k];
        return r;
    endfunction

    always @(posedge clk) begin
        bit [NP-1:0] hit, clr, nst;
        bit [31:0] rd;
        int bk, rg;
        if (!rst_n) begin
            m_lvl = '0; m_drv = '0; m_trig = '0; m_pol = '0; m_msk = '0;
            m_pend = '0; m_s1 = '0; m_s2 = '0; m_prev = '0; m_rd = '0;
        end else begin
            bk = int'(bus_addr[5:3]);
            rg = int'(bus_addr[2:0]);
            for (int p = 0; p < NP; p++) begin
                if (m_trig[p]) hit[p] = m_pol[p] ? (m_s2[p] & ~m_prev[p]) : (~m_s2[p] & m_prev[p]);
                else           hit[p] = (m_s2[p] == m_pol[p]);
            end
            nst = m_pend | (hit & m_msk);
            clr = '0;
            rd  = (bus_valid && !bus_write) ? mread(bk, rg) : 32'h0;
            if (bus_valid && bus_write && bk < 5) begin
                for (int k = 0; k < bw(bk); k++) begin
                    case (rg)
                        0: m_lvl[bb(bk)+k]  = bus_wdata[k];
                        1: m_drv[bb(bk)+k]  = bus_wdata[k];
                        3: m_trig[bb(bk)+k] = bus_wdata[k];
                        4: m_pol[bb(bk)+k]  = bus_wdata[k];
                        5: m_msk[bb(bk)+k]  = bus_wdata[k];
                        6: clr[bb(bk)+k]    = bus_wdata[k];
                        default: ;
                    endcase
                end
            end
            m_pend = nst & ~clr;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pad_in;
            m_rd   = rd;
        end
    end

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (phase %s) act=%h exp=%h", req, tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2 pad_out", 128'(pad_out), 128'(m_lvl));
            chk("R2 pad_oe",  128'(pad_oe),  128'(m_drv));
            chk("R8 irq",     128'(irq),     128'(|(m_pend & m_msk)));
            chk("R10 rdata",  128'(bus_rdata), 128'(m_rd));
        end
    end

    task automatic bus_wr(int bk, int rg, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1;
        bus_addr = {3'(bk), 3'(rg)}; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd_expect(string req, int bk, int rg, logic [31:0] exp);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = {3'(bk), 3'(rg)};
        @(posedge clk); #1;
        bus_valid = 1'b0;
        @(negedge clk);
        chk(req, 128'(bus_rdata), 128'(exp));
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 pad_out", 128'(pad_out), 128'h0);
        chk("R11 pad_oe",  128'(pad_oe),  128'h0);
        chk("R11 irq",     128'(irq),     128'h0);
        chk("R11 rdata",   128'(bus_rdata), 128'h0);
        cmp_on = 1;
        rd_expect("R11 pend", 0, 7, 32'h0);

        // R1 / R2: pin 43 is bit 0 of bank 2
        tag = "R1";
        bus_wr(2, 0, 32'h1);
        bus_wr(2, 1, 32'h1);
        @(negedge clk);
        chk("R1 pin43 out", 128'(pad_out[43]), 128'h1);
        chk("R1 pin43 oe",  128'(pad_oe[43]),  128'h1);
        chk("R1 pin42 out", 128'(pad_out[42]), 128'h0);

        // R9: upper bits and void banks
        tag = "R9";
        bus_wr(0, 0, 32'hFFFF_FFFF);
        rd_expect("R9 bank0 width", 0, 0, 32'h0000_FFFF);
        bus_wr(4, 1, 32'hFFFF_FFFF);
        rd_expect("R9 bank4 width", 4, 1, 32'h0000_0FFF);
        bus_wr(5, 0, 32'hFFFF_FFFF);
        rd_expect("R9 bank5 read", 5, 0, 32'h0);
        rd_expect("R9 ack reads 0", 1, 6, 32'h0);
        bus_wr(1, 0, 32'h0);
        rd_expect("R9 bank1 untouched by bank5 write", 1, 0, 32'h0);

        // R3: synchronized input, driven pins too
        tag = "R3";
        pad_in[20] = 1'b1; pad_in[0] = 1'b1; pad_in[106] = 1'b1;
        idle(3);
        rd_expect("R3 bank1 in", 1, 2, 32'h10);
        rd_expect("R3 bank0 in driven", 0, 2, 32'h1);
        rd_expect("R3 bank4 in", 4, 2, 32'h800);
        pad_in[20] = 1'b0;

        // R4 / R7 / R8: edges on pins 16 (rising) and 17 (falling)
        tag = "R4";
        pad_in[17] = 1'b1;
        idle(4);
        bus_wr(1, 3, 32'h3);
        bus_wr(1, 4, 32'h1);
        bus_wr(1, 5, 32'h3);
        idle(2);
        rd_expect("R4 no event yet", 1, 7, 32'h0);
        pad_in[16] = 1'b1;
        idle(4);
        rd_expect("R4 rising pend", 1, 7, 32'h1);
        chk("R8 irq on pend", 128'(irq), 128'h1);
        tag = "R7";
        bus_wr(1, 6, 32'h0);
        rd_expect("R7 zero write no effect", 1, 7, 32'h1);
        bus_wr(1, 6, 32'h1);
        rd_expect("R7 one clears", 1, 7, 32'h0);
        chk("R8 irq after clear", 128'(irq), 128'h0);
        tag = "R4";
        pad_in[17] = 1'b0;
        idle(4);
        rd_expect("R4 falling pend", 1, 7, 32'h2);
        bus_wr(1, 6, 32'h2);

        // R5: level high on pin 0
        tag = "R5";
        bus_wr(0, 4, 32'h1);
        bus_wr(0, 5, 32'h1);
        idle(2);
        rd_expect("R5 level pend", 0, 7, 32'h1);
        bus_wr(0, 6, 32'h1);
        rd_expect("R5 cleared one cycle", 0, 7, 32'h0);
        rd_expect("R5 re-pends", 0, 7, 32'h1);
        pad_in[0] = 1'b0;
        idle(3);
        bus_wr(0, 6, 32'h1);
        rd_expect("R5 stays clear when inactive", 0, 7, 32'h0);

        // R6: masked-off pin 95 rising
        tag = "R6";
        bus_wr(4, 3, 32'h1);
        bus_wr(4, 4, 32'h1);
        pad_in[95] = 1'b1;
        idle(4);
        rd_expect("R6 masked no pend", 4, 7, 32'h0);
        chk("R6 irq low", 128'(irq), 128'h0);
        bus_wr(1, 5, 32'h1);
        pad_in[16] = 1'b0; idle(2); pad_in[16] = 1'b1;
        idle(4);
        bus_wr(1, 5, 32'h0);
        rd_expect("R6 pend kept after unmask", 1, 7, 32'h1);
        chk("R6 irq masked", 128'(irq), 128'h0);

        // Random traffic against the model
        tag = "RAND";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 3) == 0)
                pad_in = pad_in ^ {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
            bus_valid = ($urandom_range(0, 9) < 7);
            bus_write = $urandom_range(0, 1) == 1;
            bus_addr  = 6'($urandom);
            bus_wdata = $urandom;
        end
        @(negedge clk);
        bus_valid = 1'b0;
        idle(4);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule